// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading two levels of translation tables from memory. A request is accepted only while the walker is idle. The walker first reads a directory entry. It finds that entry from a loadable directory base register and the upper ten address bits. If that entry is present, the walker reads a table entry from the table the directory entry points to, indexed by the next ten address bits. If that second entry is also present, the page frame it names is joined with the low twelve offset bits of the request. Pages are 4096 bytes.

If either entry has its present bit clear, the walker stops. It returns a fault response instead of an address. The response carries the linear address that faulted and the level at which the walk stopped. Every response is a single-cycle pulse, and the walker then becomes idle again. Memory reads use a valid/ready handshake. The read data is taken in the cycle where both signals are high, so a slow memory can stall the walk for any number of cycles.

The directory base register is written through a separate strobe. A write is honoured only while the walker is idle. A write that arrives during a walk is dropped.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `rsp_valid` and `mem_valid` are 0, and the directory base register holds zero.
- R2: After a request is accepted, the first memory read goes to address base + 4 × laddr[31:22], where base is the 4 KB-aligned directory base.
- R3: When the directory entry is present, the second read goes to entry[31:12]·4096 + 4 × laddr[21:12].
- R4: When both entries are present, the response has `rsp_fault` = 0 and `rsp_paddr` = {table entry[31:12], laddr[11:0]}. Entry bits 11:1 never reach the address.
- R5: A directory entry with bit 0 (present) equal to 0 gives a fault response with `rsp_level` = 0. No second read is made.
- R6: A table entry with bit 0 equal to 0 gives a fault response with `rsp_level` = 1.
- R7: Every response, fault or not, sets `rsp_valid` for exactly one cycle and returns `rsp_laddr` equal to the request's linear address. The cycle after it, `req_ready` is 1.
- R8: `req_ready` is 0 from the cycle after acceptance until the response has been given. Requests presented in that window are not taken.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid` and `mem_addr` hold their values into the next cycle.
- R10: A base write in an idle cycle takes effect at once, including for a request accepted in that same cycle. A base write during a walk is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request present |
| req_laddr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle, request taken when req_valid is high |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_level | output | 1 | Faulting level: 0 directory, 1 table |
| rsp_paddr | output | 32 | Physical address (valid when rsp_fault is 0) |
| rsp_laddr | output | 32 | Linear address of the walk (faulting address on a fault) |
| mem_valid | output | 1 | Entry read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ready | input | 1 | Memory accepts the read; mem_rdata valid this cycle |
| mem_rdata | input | 32 | Entry data |
| base_wr_en | input | 1 | Directory base write strobe |
| base_wr_data | input | 32 | New directory base, bits 11:0 ignored |

## Verification
The bench goes after index extremes: directory index 0x3FF, table index 0x3FF, and offsets 0x000 and 0xFFF. A design that swapped or shifted the index fields would read the wrong entry and return a wrong frame. Entries with flag bits set in 11:1 expose a design that leaks entry bits into the physical address. Faults at each level expose a design that mislabels the level or makes a second read after a missing directory entry. Memory stalls expose a walker that drops its address early. Base writes during a walk, and in the same cycle as an accepted request, expose a walker whose base register is not frozen, or whose first read uses a stale base.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_RD_TBL,
    ST_OK,
    ST_FLT
  } walk_st_t;

  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_TBL = 1'b1;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int LA_W     = 32,
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10,
  parameter int OFS_BITS = 12,
  parameter int ENT_LOG2 = 2
) (
  input  logic [LA_W-OFS_BITS-1:0] base_frame,
  input  logic [LA_W-OFS_BITS-1:0] dir_frame,
  input  logic [LA_W-OFS_BITS-1:0] pte_frame,
  input  logic [LA_W-1:0]          laddr,
  input  logic                     sel_tbl,
  output logic [LA_W-1:0]          entry_addr,
  output logic [LA_W-1:0]          paddr
);
  localparam int FRAME_W = LA_W - OFS_BITS;
  localparam int TBL_LSB = OFS_BITS;
  localparam int DIR_LSB = OFS_BITS + TBL_BITS;

  logic [DIR_BITS-1:0] dir_idx;
  logic [TBL_BITS-1:0] tbl_idx;
  logic [LA_W-1:0]     root;
  logic [LA_W-1:0]     step;

  assign dir_idx = laddr[DIR_LSB +: DIR_BITS];
  assign tbl_idx = laddr[TBL_LSB +: TBL_BITS];

  // entry address = table base + index * entry size
  always_comb begin
    if (sel_tbl) begin
      root = {dir_frame, {OFS_BITS{1'b0}}};
      step = LA_W'(tbl_idx) << ENT_LOG2;
    end else begin
      root = {base_frame, {OFS_BITS{1'b0}}};
      step = LA_W'(dir_idx) << ENT_LOG2;
    end
    entry_addr = root + step;
  end

  assign paddr = {pte_frame[FRAME_W-1:0], laddr[OFS_BITS-1:0]};
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int LA_W        = 32,
  parameter int OFS_BITS    = 12,
  parameter int PRESENT_BIT = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [LA_W-1:0]          req_laddr,
  output logic                     req_ready,
  input  logic                     mem_ready,
  input  logic [LA_W-1:0]          mem_rdata,
  output logic                     mem_valid,
  output logic                     sel_tbl,
  output logic [LA_W-1:0]          laddr_q,
  output logic [LA_W-OFS_BITS-1:0] dir_frame_q,
  output logic [LA_W-OFS_BITS-1:0] pte_frame_q,
  output logic                     rsp_valid,
  output logic                     rsp_fault,
  output logic                     rsp_level
);
  localparam int FRAME_W = LA_W - OFS_BITS;

  walk_st_t state_q, state_d;
  logic     ld_la, ld_dir, ld_pte, ld_lvl;
  logic     lvl_q, lvl_d;
  logic     present;

  assign present = mem_rdata[PRESENT_BIT];

  always_comb begin
    state_d = state_q;
    ld_la   = 1'b0;
    ld_dir  = 1'b0;
    ld_pte  = 1'b0;
    ld_lvl  = 1'b0;
    lvl_d   = lvl_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_la   = 1'b1;
          state_d = ST_RD_DIR;
        end
      end
      ST_RD_DIR: begin
        if (mem_ready) begin
          if (present) begin
            ld_dir  = 1'b1;
            state_d = ST_RD_TBL;
          end else begin
            ld_lvl  = 1'b1;
            lvl_d   = LVL_DIR;
            state_d = ST_FLT;
          end
        end
      end
      ST_RD_TBL: begin
        if (mem_ready) begin
          if (present) begin
            ld_pte  = 1'b1;
            state_d = ST_OK;
          end else begin
            ld_lvl  = 1'b1;
            lvl_d   = LVL_TBL;
            state_d = ST_FLT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= LVL_DIR;
    end else begin
      state_q <= state_d;
      if (ld_lvl) lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_la)  laddr_q     <= req_laddr;
    if (ld_dir) dir_frame_q <= mem_rdata[LA_W-1 -: FRAME_W];
    if (ld_pte) pte_frame_q <= mem_rdata[LA_W-1 -: FRAME_W];
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_valid = (state_q == ST_RD_DIR) || (state_q == ST_RD_TBL);
  assign sel_tbl   = (state_q == ST_RD_TBL);
  assign rsp_valid = (state_q == ST_OK) || (state_q == ST_FLT);
  assign rsp_fault = (state_q == ST_FLT);
  assign rsp_level = lvl_q;

  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_valid && !sel_tbl));

  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_dir_miss_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !sel_tbl && !present) |=> (rsp_fault && rsp_level == LVL_DIR));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int LA_W        = 32,
  parameter int DIR_BITS    = 10,
  parameter int TBL_BITS    = 10,
  parameter int OFS_BITS    = 12,
  parameter int ENT_LOG2    = 2,
  parameter int PRESENT_BIT = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [LA_W-1:0] req_laddr,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic            rsp_level,
  output logic [LA_W-1:0] rsp_paddr,
  output logic [LA_W-1:0] rsp_laddr,
  output logic            mem_valid,
  output logic [LA_W-1:0] mem_addr,
  input  logic            mem_ready,
  input  logic [LA_W-1:0] mem_rdata,
  input  logic            base_wr_en,
  input  logic [LA_W-1:0] base_wr_data
);
  localparam int FRAME_W = LA_W - OFS_BITS;

  logic               rst_sync_n;
  logic [FRAME_W-1:0] base_q;
  logic               base_ld;
  logic               sel_tbl;
  logic [FRAME_W-1:0] dir_frame_q;
  logic [FRAME_W-1:0] pte_frame_q;
  logic [LA_W-1:0]    laddr_q;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_multi
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = sync_q[SYNC_STAGES-1];
    end else begin : g_sync_single
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_sync_n = sync_q;
    end
  endgenerate

  // base register: clock enable only while the walker is idle
  assign base_ld = base_wr_en && req_ready;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  base_q <= '0;
    else if (base_ld) base_q <= base_wr_data[LA_W-1 -: FRAME_W];
  end

  pgwalk_ctrl #(
    .LA_W        (LA_W),
    .OFS_BITS    (OFS_BITS),
    .PRESENT_BIT (PRESENT_BIT)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .req_laddr   (req_laddr),
    .req_ready   (req_ready),
    .mem_ready   (mem_ready),
    .mem_rdata   (mem_rdata),
    .mem_valid   (mem_valid),
    .sel_tbl     (sel_tbl),
    .laddr_q     (laddr_q),
    .dir_frame_q (dir_frame_q),
    .pte_frame_q (pte_frame_q),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_level   (rsp_level)
  );

  pgwalk_addr #(
    .LA_W     (LA_W),
    .DIR_BITS (DIR_BITS),
    .TBL_BITS (TBL_BITS),
    .OFS_BITS (OFS_BITS),
    .ENT_LOG2 (ENT_LOG2)
  ) addr_i (
    .base_frame (base_q),
    .dir_frame  (dir_frame_q),
    .pte_frame  (pte_frame_q),
    .laddr      (laddr_q),
    .sel_tbl    (sel_tbl),
    .entry_addr (mem_addr),
    .paddr      (rsp_paddr)
  );

  assign rsp_laddr = laddr_q;

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  assert_base_frozen_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_ready |=> $stable(base_q));

  assert_offset_passthru_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFS_BITS-1:0] == rsp_laddr[OFS_BITS-1:0]));
endmodule

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  typedef struct packed {
    logic [31:0] la;
    logic        flt;
    logic        lvl;
    logic [31:0] pa;
    logic [31:0] dir_rd;
    logic [31:0] tbl_rd;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0040_2345, 1'b0, 1'b0, 32'hABCD_E345, 32'h0010_0004, 32'h0020_0008, 2'd2},
    '{32'h007F_FFFF, 1'b0, 1'b0, 32'h1234_5FFF, 32'h0010_0004, 32'h0020_0FFC, 2'd2},
    '{32'hFFC0_0000, 1'b0, 1'b0, 32'h0000_1000, 32'h0010_0FFC, 32'h0030_0000, 2'd2},
    '{32'h0000_0ABC, 1'b1, 1'b0, 32'h0000_0000, 32'h0010_0000, 32'h0000_0000, 2'd1},
    '{32'h0040_5123, 1'b1, 1'b1, 32'h0000_0000, 32'h0010_0004, 32'h0020_0014, 2'd2},
    '{32'h0080_0000, 1'b1, 1'b0, 32'h0000_0000, 32'h0010_0008, 32'h0000_0000, 2'd1}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_laddr;
  logic        req_ready;
  logic        rsp_valid;
  logic        rsp_fault;
  logic        rsp_level;
  logic [31:0] rsp_paddr;
  logic [31:0] rsp_laddr;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic        mem_ready;
  logic [31:0] mem_rdata;
  logic        base_wr_en;
  logic [31:0] base_wr_data;

  int total;
  int bad;
  int stall_cfg;
  int wait_cnt;
  int rd_cnt;
  logic [31:0] rd_log [4];
  logic [31:0] mem_img [logic [31:0]];

  logic        got_flt;
  logic        got_lvl;
  logic [31:0] got_pa;
  logic [31:0] got_la;

  pgwalk_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_laddr    (req_laddr),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_level    (rsp_level),
    .rsp_paddr    (rsp_paddr),
    .rsp_laddr    (rsp_laddr),
    .mem_valid    (mem_valid),
    .mem_addr     (mem_addr),
    .mem_ready    (mem_ready),
    .mem_rdata    (mem_rdata),
    .base_wr_en   (base_wr_en),
    .base_wr_data (base_wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] lookup(input logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: answers after stall_cfg waiting cycles, logs read addresses
  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    wait_cnt  = 0;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      if (mem_valid) begin
        if (wait_cnt <= 0) begin
          mem_ready = 1'b1;
          mem_rdata = lookup(mem_addr);
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
          wait_cnt = stall_cfg;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic start_req(input logic [31:0] la);
    @(negedge clk);
    rd_cnt    = 0;
    req_valid = 1'b1;
    req_laddr = la;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input string tag);
    int n;
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!rsp_valid) begin
      total++;
      bad++;
      $display("FAIL %s no response actual=0 expected=1", tag);
    end
    got_flt = rsp_fault;
    got_lvl = rsp_level;
    got_pa  = rsp_paddr;
    got_la  = rsp_laddr;
    @(negedge clk);
    check({tag, " R7 pulse"}, {31'b0, rsp_valid}, 32'd0);
    check({tag, " R7 ready"}, {31'b0, req_ready}, 32'd1);
  endtask

  task automatic write_base(input logic [31:0] v);
    @(negedge clk);
    base_wr_en   = 1'b1;
    base_wr_data = v;
    @(negedge clk);
    base_wr_en   = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    start_req(v.la);
    wait_rsp(tag);
    check({tag, " R2 dir read"}, rd_log[0], v.dir_rd);
    check({tag, " R7 laddr"}, got_la, v.la);
    check({tag, " R5 read count"}, 32'(rd_cnt), 32'(v.nrd));
    if (v.nrd == 2) check({tag, " R3 tbl read"}, rd_log[1], v.tbl_rd);
    check({tag, " R6 fault"}, {31'b0, got_flt}, {31'b0, v.flt});
    if (v.flt) check({tag, " R6 level"}, {31'b0, got_lvl}, {31'b0, v.lvl});
    else       check({tag, " R4 paddr"}, got_pa, v.pa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; stall_cfg = 0; rd_cnt = 0;
    req_valid = 1'b0; req_laddr = '0;
    base_wr_en = 1'b0; base_wr_data = '0;
    mem_img[32'h0010_0000] = 32'h0040_0000;
    mem_img[32'h0010_0004] = 32'h0020_0001;
    mem_img[32'h0010_0FFC] = 32'h0030_0001;
    mem_img[32'h0020_0008] = 32'hABCD_E001;
    mem_img[32'h0020_0FFC] = 32'h1234_5001;
    mem_img[32'h0030_0000] = 32'h0000_1FFF;
    mem_img[32'h0020_0014] = 32'hFFFF_F000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle after reset
    check("R1 req_ready", {31'b0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
    // R1: base is zero -> directory read at 0 + 4*1
    start_req(32'h0040_2345);
    wait_rsp("R1 base zero");
    check("R1 base zero dir read", rd_log[0], 32'h0000_0004);
    check("R1 base zero fault", {31'b0, got_flt}, 32'd1);

    write_base(32'h0010_0ABC);

    foreach (VECS[i]) run_vec(VECS[i], $sformatf("vec%0d", i));

    // R9: same walks under memory stalls
    stall_cfg = 3;
    run_vec(VECS[0], "R9 stall ok");
    run_vec(VECS[4], "R9 stall tbl fault");

    // R8 and R10: requests and base writes during a walk are dropped
    stall_cfg = 4;
    start_req(VECS[1].la);
    check("R8 busy ready", {31'b0, req_ready}, 32'd0);
    req_valid    = 1'b1;
    req_laddr    = 32'h0000_0ABC;
    base_wr_en   = 1'b1;
    base_wr_data = 32'h0090_0000;
    @(negedge clk);
    @(negedge clk);
    req_valid  = 1'b0;
    base_wr_en = 1'b0;
    wait_rsp("R8 busy walk");
    check("R8 busy walk paddr", got_pa, VECS[1].pa);
    check("R8 busy walk laddr", got_la, VECS[1].la);
    check("R8 no extra walk", {31'b0, mem_valid}, 32'd0);
    stall_cfg = 0;
    run_vec(VECS[3], "R10 busy write dropped");

    // R10: write in the same idle cycle as an accepted request
    @(negedge clk);
    rd_cnt       = 0;
    req_valid    = 1'b1;
    req_laddr    = 32'h0040_2345;
    base_wr_en   = 1'b1;
    base_wr_data = 32'h0050_0000;
    @(negedge clk);
    req_valid  = 1'b0;
    base_wr_en = 1'b0;
    wait_rsp("R10 same cycle");
    check("R10 same cycle dir read", rd_log[0], 32'h0050_0004);
    check("R10 same cycle fault", {31'b0, got_flt}, 32'd1);
    check("R10 same cycle level", {31'b0, got_lvl}, 32'd0);

    write_base(32'h0010_0000);
    run_vec(VECS[2], "R10 restored base");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule